// File: doc/BRIEF.md
# SDIO Card Interrupt Detector with ReadWait Pause

This block watches data line 1 of an SD bus to recognise interrupts raised by an SDIO card, and it lets the host suspend a running data transfer so that commands can be sent in the middle of it. On a one-bit bus, line 1 carries no data. A low level on it is a plain level interrupt. On a four-bit bus, line 1 carries data while a transfer runs. The card's interrupt is then valid only in a short window that opens right after the final byte of each block. A low seen inside that window is latched until software clears it. When no transfer is running, a four-bit bus is watched as a level interrupt, in the same way as a one-bit bus.

The same block keeps the byte position inside the current block and the count of completed blocks. A ReadWait request is accepted only while a transfer is active and the byte position is at a block boundary. While the pause is held, byte strobes are ignored and both counters keep their values. The bus clock enable keeps ticking during the pause, so the line is still sampled. When the pause is released, counting resumes from the held values. All bus events (line samples, byte strobes, window steps) take effect on system clock edges where the bus clock enable is high. The host controls (ReadWait request, ReadWait release, interrupt clear) act on any system clock edge.

Top module: `sdio_irq_rw`

## Requirements
- R1: After reset, irq and pause are 0 and byte_cnt and blk_cnt are 0.
- R2: With wide_bus=0, each edge with sd_tick=1 stores the inverse of dat1. From the next cycle on, irq equals that stored value, so irq is 1 while dat1 is low and 0 once dat1 is high.
- R3: A byte is accepted on an edge with sd_tick=1, byte_stb=1, xfer_active=1 and pause=0. Each accepted byte advances byte_cnt. The byte that brings byte_cnt from BLOCK_BYTES-1 back to 0 also adds one to blk_cnt. A strobe without sd_tick is not counted.
- R4: With wide_bus=1 and xfer_active=1, a low dat1 outside the sampling window leaves irq at 0.
- R5: With wide_bus=1, the sampling window covers the WIN_CYC sd_tick edges that follow the edge accepting the last byte of a block. A low dat1 on any of them sets the latched interrupt, and irq is 1 from the next cycle on.
- R6: The latched interrupt stays set until irq_clr=1 on an edge. If a window sample sets it on the same edge, the set wins.
- R7: With wide_bus=1 and xfer_active=0, irq behaves as in R2.
- R8: rw_req sets pause on the next edge only if xfer_active=1 and byte_cnt=0. Otherwise it is ignored, and counting continues.
- R9: While pause=1, byte strobes are ignored and byte_cnt and blk_cnt hold. Line sampling, including a window that is already open, continues.
- R10: rw_release clears pause on the next edge, and takes priority over rw_req. Counting then resumes from the held values.
- R11: xfer_active=0 clears pause, byte_cnt and blk_cnt on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sd_tick | input | 1 | Bus clock enable, one system cycle per bus clock |
| wide_bus | input | 1 | 1 selects the four-bit bus, 0 the one-bit bus |
| dat1 | input | 1 | Sampled level of data line 1 |
| byte_stb | input | 1 | Data path has moved one byte |
| xfer_active | input | 1 | A data transfer is in progress |
| rw_req | input | 1 | Request to enter ReadWait |
| rw_release | input | 1 | Request to leave ReadWait |
| irq_clr | input | 1 | Software clear of the latched window interrupt |
| irq | output | 1 | Level interrupt to the host |
| pause | output | 1 | Freeze for the transfer counters (ReadWait held) |
| byte_cnt | output | $clog2(BLOCK_BYTES) | Byte position within the current block |
| blk_cnt | output | BLK_W | Blocks completed in this transfer |

## Verification
The assertions assume that the data path raises byte_stb only together with sd_tick. They also assume that wide_bus changes only while no line sample is in flight, because the level path and the window path both read it. The stimulus keeps to this. Every byte strobe is issued inside a bus-tick task. The bus width is set only between sweeps, while the bench drives no ticks. ReadWait requests are sent on cycles without a strobe, so an accepted request always finds a steady byte position.

// File: rtl/sdio_irq_pkg.sv
package sdio_irq_pkg;

   typedef enum logic {
      RW_RUN  = 1'b0,
      RW_HOLD = 1'b1
   } rw_state_e;

   // line 1 acts as a plain level interrupt unless a four-bit transfer runs
   function automatic logic level_mode(input logic wide, input logic active);
      return (!wide) || (!active);
   endfunction

endpackage

// File: rtl/sdio_xfer_counter.sv
module sdio_xfer_counter #(
   parameter int BLOCK_BYTES = 512,
   parameter int BLK_W       = 16,
   localparam int CNT_W      = $clog2(BLOCK_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             stb,
   input  logic             active,
   input  logic             hold,
   output logic [CNT_W-1:0] byte_cnt,
   output logic [BLK_W-1:0] blk_cnt,
   output logic             blk_end,
   output logic             at_boundary
);

   localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(BLOCK_BYTES - 1);

   logic [CNT_W-1:0] cnt_q;
   logic [BLK_W-1:0] blk_q;
   logic             accept;

   assign accept      = tick && stb && active && !hold;
   assign blk_end     = accept && (cnt_q == LAST_BYTE);
   assign at_boundary = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         blk_q <= '0;
      end else if (!active) begin
         cnt_q <= '0;
         blk_q <= '0;
      end else if (accept) begin
         if (blk_end) begin
            cnt_q <= '0;
            blk_q <= blk_q + BLK_W'(1);
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

   assign byte_cnt = cnt_q;
   assign blk_cnt  = blk_q;

endmodule

// File: rtl/sdio_rw_ctrl.sv
module sdio_rw_ctrl
   import sdio_irq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic at_boundary,
   input  logic req,
   input  logic rel,
   output logic pause
);

   rw_state_e state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RW_RUN;
      end else if (!active || rel) begin
         state_q <= RW_RUN;
      end else if (req && at_boundary) begin
         state_q <= RW_HOLD;
      end
   end

   assign pause = (state_q == RW_HOLD);

endmodule

// File: rtl/sdio_irq_level.sv
module sdio_irq_level (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic dat1,
   output logic low_seen
);

   logic low_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_q <= 1'b0;
      end else if (tick) begin
         low_q <= !dat1;
      end
   end

   assign low_seen = low_q;

endmodule

// File: rtl/sdio_irq_window.sv
module sdio_irq_window #(
   parameter int WIN_CYC = 2,
   localparam int WCW    = $clog2(WIN_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic load,
   input  logic dat1,
   input  logic clr,
   output logic latched
);

   logic win_open;
   logic hit;
   logic latch_q;

   generate
      if (WIN_CYC == 1) begin : g_flag
         logic open_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               open_q <= 1'b0;
            end else if (load) begin
               open_q <= 1'b1;
            end else if (tick) begin
               open_q <= 1'b0;
            end
         end
         assign win_open = open_q;
      end else begin : g_count
         logic [WCW-1:0] left_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               left_q <= '0;
            end else if (load) begin
               left_q <= WCW'(WIN_CYC);
            end else if (tick && (left_q != '0)) begin
               left_q <= left_q - WCW'(1);
            end
         end
         assign win_open = (left_q != '0);
      end
   endgenerate

   assign hit = win_open && tick && !dat1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= 1'b0;
      end else if (hit) begin
         latch_q <= 1'b1;
      end else if (clr) begin
         latch_q <= 1'b0;
      end
   end

   assign latched = latch_q;

endmodule

// File: rtl/sdio_irq_rw.sv
module sdio_irq_rw
   import sdio_irq_pkg::*;
#(
   parameter int BLOCK_BYTES = 512,
   parameter int WIN_CYC     = 2,
   parameter int BLK_W       = 16,
   localparam int CNT_W      = $clog2(BLOCK_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sd_tick,
   input  logic             wide_bus,
   input  logic             dat1,
   input  logic             byte_stb,
   input  logic             xfer_active,
   input  logic             rw_req,
   input  logic             rw_release,
   input  logic             irq_clr,
   output logic             irq,
   output logic             pause,
   output logic [CNT_W-1:0] byte_cnt,
   output logic [BLK_W-1:0] blk_cnt
);

   generate
      if (BLOCK_BYTES < 2) begin : g_bad_block
         $error("BLOCK_BYTES must be at least 2");
      end
      if (WIN_CYC < 1) begin : g_bad_window
         $error("WIN_CYC must be at least 1");
      end
      if (WIN_CYC >= BLOCK_BYTES) begin : g_bad_overlap
         $error("WIN_CYC must be shorter than a block");
      end
      if (BLK_W < 1) begin : g_bad_blk
         $error("BLK_W must be at least 1");
      end
   endgenerate

   logic blk_end;
   logic at_boundary;
   logic win_irq;
   logic low_seen;

   sdio_xfer_counter #(
      .BLOCK_BYTES (BLOCK_BYTES),
      .BLK_W       (BLK_W)
   ) u_count (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (sd_tick),
      .stb         (byte_stb),
      .active      (xfer_active),
      .hold        (pause),
      .byte_cnt    (byte_cnt),
      .blk_cnt     (blk_cnt),
      .blk_end     (blk_end),
      .at_boundary (at_boundary)
   );

   sdio_rw_ctrl u_rw (
      .clk         (clk),
      .rst_n       (rst_n),
      .active      (xfer_active),
      .at_boundary (at_boundary),
      .req         (rw_req),
      .rel         (rw_release),
      .pause       (pause)
   );

   sdio_irq_level u_level (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (sd_tick),
      .dat1     (dat1),
      .low_seen (low_seen)
   );

   sdio_irq_window #(
      .WIN_CYC (WIN_CYC)
   ) u_window (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (sd_tick),
      .load    (blk_end && wide_bus),
      .dat1    (dat1),
      .clr     (irq_clr),
      .latched (win_irq)
   );

   assign irq = win_irq || (level_mode(wide_bus, xfer_active) && low_seen);

endmodule

// File: rtl/sdio_irq_rw_chk.sv
module sdio_irq_rw_chk #(
   parameter int BLOCK_BYTES = 512,
   parameter int BLK_W       = 16,
   localparam int CNT_W      = $clog2(BLOCK_BYTES)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sd_tick,
   input logic             wide_bus,
   input logic             dat1,
   input logic             xfer_active,
   input logic             irq_clr,
   input logic             irq,
   input logic             pause,
   input logic [CNT_W-1:0] byte_cnt,
   input logic [BLK_W-1:0] blk_cnt,
   input logic             win_irq
);

   // R8: a pause only starts from an active transfer sitting on a block boundary
   assert_pause_at_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pause) |-> ($past(xfer_active) && ($past(byte_cnt) == '0)));

   // R9: counters hold across consecutive paused cycles
   assert_counters_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pause && $past(pause)) |-> ($stable(byte_cnt) && $stable(blk_cnt)));

   // R11: end of transfer clears pause and counters
   assert_idle_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_active |=> (!pause && (byte_cnt == '0) && (blk_cnt == '0)));

   // R2 and R7: a low sample in level mode raises irq on the next cycle
   assert_level_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_tick && !dat1 && (!wide_bus || !xfer_active)) |=> (irq || (wide_bus && xfer_active)));

   // R6: the latched window interrupt persists until cleared
   assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (win_irq && !irq_clr) |=> win_irq);

endmodule

bind sdio_irq_rw sdio_irq_rw_chk #(
   .BLOCK_BYTES (BLOCK_BYTES),
   .BLK_W       (BLK_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sd_tick     (sd_tick),
   .wide_bus    (wide_bus),
   .dat1        (dat1),
   .xfer_active (xfer_active),
   .irq_clr     (irq_clr),
   .irq         (irq),
   .pause       (pause),
   .byte_cnt    (byte_cnt),
   .blk_cnt     (blk_cnt),
   .win_irq     (win_irq)
);

// File: tb/sdio_irq_rw_test.sv
module sdio_irq_rw_test;

   localparam int BB = 4;
   localparam int WC = 2;
   localparam int BW = 8;
   localparam int CW = $clog2(BB);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sd_tick = 1'b0, wide_bus = 1'b0, dat1 = 1'b1, byte_stb = 1'b0;
   logic xfer_active = 1'b0, rw_req = 1'b0, rw_release = 1'b0, irq_clr = 1'b0;
   logic irq, pause;
   logic [CW-1:0] byte_cnt;
   logic [BW-1:0] blk_cnt;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   sdio_irq_rw #(.BLOCK_BYTES(BB), .WIN_CYC(WC), .BLK_W(BW)) uut (
      .clk(clk), .rst_n(rst_n), .sd_tick(sd_tick), .wide_bus(wide_bus),
      .dat1(dat1), .byte_stb(byte_stb), .xfer_active(xfer_active),
      .rw_req(rw_req), .rw_release(rw_release), .irq_clr(irq_clr),
      .irq(irq), .pause(pause), .byte_cnt(byte_cnt), .blk_cnt(blk_cnt));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic idle();
      @(posedge clk);
      #1;
   endtask

   task automatic tick(input logic stb, input logic d1);
      sd_tick = 1'b1; byte_stb = stb; dat1 = d1;
      idle();
      sd_tick = 1'b0; byte_stb = 1'b0;
   endtask

   task automatic pulse_req();
      rw_req = 1'b1; idle(); rw_req = 1'b0;
   endtask

   task automatic pulse_rel();
      rw_release = 1'b1; idle(); rw_release = 1'b0;
   endtask

   task automatic pulse_clr();
      irq_clr = 1'b1; idle(); irq_clr = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) idle();
      rst_n = 1'b1;
      idle();
      // R1 reset state
      chk("R1 irq", irq, 0);
      chk("R1 pause", pause, 0);
      chk("R1 byte_cnt", byte_cnt, 0);
      chk("R1 blk_cnt", blk_cnt, 0);

      // R2: one-bit bus, every four-sample pattern, idle and during a transfer
      wide_bus = 1'b0;
      for (int act = 0; act < 2; act++) begin
         xfer_active = act[0];
         for (int pat = 0; pat < 16; pat++) begin
            for (int b = 0; b < 4; b++) begin
               tick(1'b0, pat[b]);
               chk("R2 irq follows line", irq, {31'd0, !pat[b]});
            end
         end
      end
      tick(1'b0, 1'b1);
      xfer_active = 1'b0;
      idle();

      // R7: four-bit bus with no transfer is a level interrupt
      wide_bus = 1'b1;
      tick(1'b0, 1'b0);
      chk("R7 low raises", irq, 1);
      tick(1'b0, 1'b1);
      chk("R7 high clears", irq, 0);

      // R3: byte counting sweep on the one-bit bus
      wide_bus = 1'b0;
      xfer_active = 1'b1;
      idle();
      for (int n = 1; n <= 10; n++) begin
         tick(1'b1, 1'b1);
         chk("R3 byte_cnt", byte_cnt, n % BB);
         chk("R3 blk_cnt", blk_cnt, n / BB);
      end
      byte_stb = 1'b1; idle(); byte_stb = 1'b0;
      chk("R3 strobe without tick", byte_cnt, 10 % BB);
      xfer_active = 1'b0;
      idle();
      chk("R11 byte_cnt cleared", byte_cnt, 0);
      chk("R11 blk_cnt cleared", blk_cnt, 0);

      // R4/R5: four-bit bus, low placed at each tick position of a block
      wide_bus = 1'b1;
      for (int p = 0; p < 8; p++) begin
         xfer_active = 1'b1;
         idle();
         for (int i = 0; i < 9; i++) begin
            tick(i < BB, (i == p) ? 1'b0 : 1'b1);
         end
         if (p == BB || p == BB + 1) begin
            chk("R5 window low latched", irq, 1);
            repeat (3) idle();
            chk("R6 latch held", irq, 1);
            pulse_clr();
            chk("R6 cleared", irq, 0);
         end else begin
            chk("R4 low outside window ignored", irq, 0);
         end
         xfer_active = 1'b0;
         idle();
      end

      // R6: set wins over a clear on the same edge
      xfer_active = 1'b1;
      idle();
      for (int i = 0; i < BB; i++) tick(1'b1, 1'b1);
      irq_clr = 1'b1;
      tick(1'b0, 1'b0);
      irq_clr = 1'b0;
      chk("R6 set beats clear", irq, 1);
      tick(1'b0, 1'b1);
      pulse_clr();
      chk("R6 cleared after", irq, 0);
      xfer_active = 1'b0;
      idle();

      // R8: requests outside an active boundary are ignored
      pulse_req();
      chk("R8 ignored while idle", pause, 0);
      xfer_active = 1'b1;
      idle();
      tick(1'b1, 1'b1);
      pulse_req();
      chk("R8 ignored mid-block", pause, 0);
      tick(1'b1, 1'b1);
      chk("R8 counting continues", byte_cnt, 2);
      tick(1'b1, 1'b1);
      tick(1'b1, 1'b1);
      chk("R3 block done", blk_cnt, 1);
      pulse_req();
      chk("R8 honoured at boundary", pause, 1);

      // R9: paused, strobes ignored, open window still sampled
      tick(1'b1, 1'b0);
      tick(1'b1, 1'b1);
      tick(1'b1, 1'b1);
      chk("R9 byte_cnt frozen", byte_cnt, 0);
      chk("R9 blk_cnt frozen", blk_cnt, 1);
      chk("R9 window sampled while paused", irq, 1);
      pulse_clr();

      // R10: release has priority and counting resumes
      rw_req = 1'b1; rw_release = 1'b1; idle();
      rw_req = 1'b0; rw_release = 1'b0;
      chk("R10 pause released", pause, 0);
      tick(1'b1, 1'b1);
      chk("R10 byte resumes", byte_cnt, 1);
      chk("R10 block kept", blk_cnt, 1);

      // R11: ending the transfer drops the pause
      for (int i = 1; i < BB; i++) tick(1'b1, 1'b1);
      chk("R3 second block", blk_cnt, 2);
      pulse_req();
      chk("R8 second pause", pause, 1);
      xfer_active = 1'b0;
      idle();
      chk("R11 pause cleared", pause, 0);
      chk("R11 counts cleared", blk_cnt, 0);
      chk("R11 irq quiet", irq, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule